// File: doc/BRIEF.md
# Byte-Serial DMA Engine with Local Buffer

This block copies a run of bytes between host memory and a private 4096-byte buffer. The buffer sits in the block's register space at offset 0x40000. Software loads a source address, a destination address and a byte count into 64-bit registers. It then writes a command word that carries a start flag, a direction flag and a completion-interrupt flag. The engine checks the whole requested range before it moves any byte. If the range is legal, it streams one byte per clock through a simple memory master port. During the transfer it steps both addresses up and the count down.

The start flag stays set for the whole transfer, so software polls it as a busy indication. When the count reaches zero and the last byte has landed, the flag clears. At that point the engine can pulse an interrupt value of 0x100 for an outside interrupt collector. A transfer is refused if its local end falls outside the buffer window, or if its host end reaches past the host address mask (28 bits by default). A refused transfer touches nothing and simply drops the start flag.

The host port has no stall. A read request returns its byte on `mem_rdata` in the clock after the request, and a write request completes in the clock it is presented. The register port is a plain strobe interface: a write takes effect at the clock edge that samples it, and read data is valid in the clock after the read strobe.

Top module: `byte_dma_engine`

## Requirements
- R1: After reset the source, destination, count and command registers read zero, `mem_req` is low and `irq_set` is zero.
- R2: The source (0x80), destination (0x88) and count (0x90) registers take a 64-bit write at their base offset. A 32-bit write at the base offset replaces the low half and keeps the high half. A 32-bit write at base+4 replaces the high half and keeps the low half. A read at the base offset returns all 64 bits, and a read at base+4 returns the high half in bits 31:0. Read data appears in the clock after `reg_rd`.
- R3: The command register (0x98) holds start in bit 0, direction in bit 1 and interrupt enable in bit 2. Start reads 1 while a transfer is pending or running and 0 once it has ended.
- R4: With direction 0, the engine issues host reads at ascending addresses from the source address, one per clock, with no gap. Each returned byte is stored in the buffer at destination minus 0x40000.
- R5: With direction 1, the engine reads buffer bytes from source minus 0x40000 upward. It writes them to host memory at ascending addresses from the destination address, one per clock, with no gap. The host port is only active while start is set.
- R6: After a completed transfer of N bytes, the source and destination registers have each advanced by N and the count register reads zero.
- R7: When interrupt enable is set, completion drives `irq_set` to 0x100 for exactly one clock, and start reads zero from the next clock on. Without interrupt enable, `irq_set` stays zero.
- R8: If the local range [base, base+N-1] is not inside 0x40000..0x40FFF, the transfer is refused. There is no host access and no buffer change, the address and count registers are unchanged, there is no interrupt, and start clears.
- R9: If the host range end base+N-1 exceeds the mask 0x0FFFFFFF, the transfer is refused with the same effects as in R8.
- R10: While start is set, writes to the source, destination, count and command registers are ignored.
- R11: Register offsets 0x40000..0x40FFF reach the buffer. A write stores `reg_wdata[7:0]`, and a read returns the byte zero-extended. While start is set, buffer writes from the register port are ignored and buffer reads return zero.
- R12: A transfer with count zero makes no host access, clears start and raises the interrupt if it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 20 | Byte offset in the block's space |
| reg_wide | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data, valid the clock after reg_rd |
| mem_req | output | 1 | Host memory request |
| mem_we | output | 1 | Host request is a write |
| mem_addr | output | 64 | Host byte address |
| mem_wdata | output | 8 | Host write byte |
| mem_rdata | input | 8 | Host read byte, one clock after the request |
| irq_set | output | 32 | Interrupt value to OR into an outside status, pulsed on completion |

## Verification
Register read data is due one clock after the read strobe, so every read task raises the strobe at a falling edge and samples `reg_rdata` at the next falling edge. Host read data is due one clock after its request, so the bench's memory model answers just after the rising edge that follows the request. The first host access is due two clocks after the command write, and after that there is one access per clock. The bench therefore records the clock number of every request and requires the last minus the first plus one to equal the byte count. Completion is checked by polling start through the read path against a bound of the count plus a few clocks, and by the one-clock interrupt pulse that the monitor counts.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

  // register offsets: software-visible layout
  localparam logic [7:0] OFF_SRC = 8'h80;
  localparam logic [7:0] OFF_DST = 8'h88;
  localparam logic [7:0] OFF_CNT = 8'h90;
  localparam logic [7:0] OFF_CMD = 8'h98;

  typedef enum logic {S_IDLE, S_RUN} seq_state_e;

  // true when [base, base+len-1] is inside [lo, hi]; an empty span always fits
  function automatic logic span_inside(input logic [63:0] base, input logic [63:0] len,
                                       input logic [63:0] lo,   input logic [63:0] hi);
    logic [64:0] last;
    if (len == 64'd0) return 1'b1;
    last = {1'b0, base} + {1'b0, len} - 65'd1;
    return (base >= lo) && (last <= {1'b0, hi});
  endfunction

  // true when the last host byte stays under the mask
  function automatic logic host_fits(input logic [63:0] base, input logic [63:0] len,
                                     input logic [63:0] mask);
    logic [64:0] last;
    if (len == 64'd0) return 1'b1;
    last = {1'b0, base} + {1'b0, len} - 65'd1;
    return last <= {1'b0, mask};
  endfunction

  // merge a 32- or 64-bit write into a 64-bit register
  function automatic logic [63:0] merge_word(input logic [63:0] old, input logic [63:0] wdata,
                                             input logic wide, input logic upper);
    if (wide)  return wdata;
    if (upper) return {wdata[31:0], old[31:0]};
    return {old[63:32], wdata[31:0]};
  endfunction

endpackage

// File: rtl/bdma_buf.sv
module bdma_buf #(
  parameter int BYTES = 4096,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       q
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (en && we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        q <= 8'h00;
    else if (en && !we) q <= mem[idx];
  end
endmodule

// File: rtl/bdma_regs.sv
module bdma_regs
  import bdma_pkg::*;
#(
  parameter int REG_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic              wide,
  input  logic [63:0]       wdata,
  input  logic              adv,
  input  logic              finish,
  input  logic              abort,
  output logic [63:0]       src_q,
  output logic [63:0]       dst_q,
  output logic [63:0]       cnt_q,
  output logic              start_q,
  output logic              dir_q,
  output logic              irqen_q,
  output logic [63:0]       rdata_q
);
  logic [REG_AW-1:0] base;
  logic              upper, wr_ok;
  logic              hit_src, hit_dst, hit_cnt, hit_cmd;
  logic [63:0]       sel;

  always_comb begin
    base    = {addr[REG_AW-1:3], 3'b000};
    upper   = addr[2];
    hit_src = base == REG_AW'(OFF_SRC);
    hit_dst = base == REG_AW'(OFF_DST);
    hit_cnt = base == REG_AW'(OFF_CNT);
    hit_cmd = base == REG_AW'(OFF_CMD);
    wr_ok   = wr && !start_q;
    if (hit_src)      sel = src_q;
    else if (hit_dst) sel = dst_q;
    else if (hit_cnt) sel = cnt_q;
    else if (hit_cmd) sel = {61'd0, irqen_q, dir_q, start_q};
    else              sel = 64'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      irqen_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (adv) begin
        src_q <= src_q + 64'd1;
        dst_q <= dst_q + 64'd1;
        cnt_q <= cnt_q - 64'd1;
      end else if (wr_ok) begin
        if (hit_src) src_q <= merge_word(src_q, wdata, wide, upper);
        if (hit_dst) dst_q <= merge_word(dst_q, wdata, wide, upper);
        if (hit_cnt) cnt_q <= merge_word(cnt_q, wdata, wide, upper);
      end
      if (finish || abort) start_q <= 1'b0;
      else if (wr_ok && hit_cmd && !upper) {irqen_q, dir_q, start_q} <= wdata[2:0];
      if (rd) rdata_q <= upper ? {32'd0, sel[63:32]} : sel;
    end
  end

  // R6
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (cnt_q == $past(cnt_q) - 64'd1) && (src_q == $past(src_q) + 64'd1));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !adv && wr) |=> (src_q == $past(src_q)) && (dst_q == $past(dst_q))
                                && (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/bdma_seq.sv
module bdma_seq
  import bdma_pkg::*;
#(
  parameter logic [63:0] BUF_BASE  = 64'h40000,
  parameter int          BUF_BYTES = 4096,
  parameter logic [63:0] HOST_MASK = 64'h0FFF_FFFF,
  parameter logic [31:0] IRQ_CODE  = 32'h100,
  localparam int IDX_W = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic             irqen,
  input  logic [63:0]      src,
  input  logic [63:0]      dst,
  input  logic [63:0]      cnt,
  input  logic [7:0]       mem_rdata_i,
  input  logic [7:0]       ram_q,
  output logic             adv_o,
  output logic             finish_o,
  output logic             abort_o,
  output logic [31:0]      irq_set_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [63:0]      mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             ram_en_o,
  output logic             ram_we_o,
  output logic [IDX_W-1:0] ram_idx_o,
  output logic [7:0]       ram_wdata_o
);
  localparam logic [63:0] BUF_LAST = BUF_BASE + 64'(BUF_BYTES) - 64'd1;

  seq_state_e  st_q;
  logic        launch_ok, issue, launch;
  logic        p_valid_q;
  logic [63:0] p_addr_q;
  logic [IDX_W-1:0] src_idx, p_idx;

  always_comb begin
    if (dir) launch_ok = span_inside(src, cnt, BUF_BASE, BUF_LAST) && host_fits(dst, cnt, HOST_MASK);
    else     launch_ok = host_fits(src, cnt, HOST_MASK) && span_inside(dst, cnt, BUF_BASE, BUF_LAST);
    launch   = (st_q == S_IDLE) && start && launch_ok;
    abort_o  = (st_q == S_IDLE) && start && !launch_ok;
    issue    = (st_q == S_RUN) && (cnt != 64'd0);
    adv_o    = issue;
    finish_o = (st_q == S_RUN) && (cnt == 64'd0) && !p_valid_q;
    irq_set_o = (finish_o && irqen) ? IRQ_CODE : 32'd0;
    src_idx  = IDX_W'(src - BUF_BASE);
    p_idx    = IDX_W'(p_addr_q - BUF_BASE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      p_valid_q <= 1'b0;
      p_addr_q  <= '0;
    end else begin
      if (launch)        st_q <= S_RUN;
      else if (finish_o) st_q <= S_IDLE;
      p_valid_q <= issue;
      if (issue) p_addr_q <= dst;
    end
  end

  // host side: a read on issue (to buffer) or a write one cycle later (from buffer)
  always_comb begin
    mem_req_o   = (issue && !dir) || (p_valid_q && dir);
    mem_we_o    = p_valid_q && dir;
    mem_addr_o  = mem_we_o ? p_addr_q : src;
    mem_wdata_o = ram_q;
    ram_we_o    = p_valid_q && !dir;
    ram_en_o    = ram_we_o || (issue && dir);
    ram_idx_o   = ram_we_o ? p_idx : src_idx;
    ram_wdata_o = mem_rdata_i;
  end

  // R4
  host_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid_q && !dir) |-> $past(mem_req_o && !mem_we_o));

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (st_q == S_IDLE) && !mem_req_o);
endmodule

// File: rtl/byte_dma_engine.sv
module byte_dma_engine
  import bdma_pkg::*;
#(
  parameter int          REG_AW    = 20,
  parameter logic [63:0] BUF_BASE  = 64'h40000,
  parameter int          BUF_BYTES = 4096,
  parameter int          HOST_AW   = 28,
  localparam int          IDX_W     = $clog2(BUF_BYTES),
  localparam logic [63:0] HOST_MASK = (64'd1 << HOST_AW) - 64'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wide,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [63:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [31:0]       irq_set
);
  logic [63:0] src_q, dst_q, cnt_q, regs_rdata;
  logic        cmd_start, cmd_dir, cmd_irqen;
  logic        adv, finish, abort;
  logic        eng_en, eng_we, bus_en, bus_we, ram_en, ram_we;
  logic [IDX_W-1:0] eng_idx, bus_idx, ram_idx;
  logic [7:0]  eng_wdata, ram_wdata, ram_q;
  logic        buf_hit, rd_buf_q, rd_buf_ok_q;
  logic [63:0] addr64;

  bdma_regs #(.REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wide(reg_wide), .wdata(reg_wdata), .adv(adv), .finish(finish), .abort(abort),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .start_q(cmd_start),
    .dir_q(cmd_dir), .irqen_q(cmd_irqen), .rdata_q(regs_rdata)
  );

  bdma_seq #(.BUF_BASE(BUF_BASE), .BUF_BYTES(BUF_BYTES), .HOST_MASK(HOST_MASK)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .dir(cmd_dir), .irqen(cmd_irqen),
    .src(src_q), .dst(dst_q), .cnt(cnt_q), .mem_rdata_i(mem_rdata), .ram_q(ram_q),
    .adv_o(adv), .finish_o(finish), .abort_o(abort), .irq_set_o(irq_set),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .ram_en_o(eng_en), .ram_we_o(eng_we), .ram_idx_o(eng_idx), .ram_wdata_o(eng_wdata)
  );

  // register-port window into the buffer; engine owns the RAM while busy
  always_comb begin
    addr64    = 64'(reg_addr);
    buf_hit   = (addr64 >= BUF_BASE) && (addr64 < BUF_BASE + 64'(BUF_BYTES));
    bus_idx   = IDX_W'(addr64 - BUF_BASE);
    bus_en    = buf_hit && !cmd_start && (reg_wr || reg_rd);
    bus_we    = buf_hit && !cmd_start && reg_wr;
    ram_en    = cmd_start ? eng_en    : bus_en;
    ram_we    = cmd_start ? eng_we    : bus_we;
    ram_idx   = cmd_start ? eng_idx   : bus_idx;
    ram_wdata = cmd_start ? eng_wdata : reg_wdata[7:0];
  end

  bdma_buf #(.BYTES(BUF_BYTES)) buf_i (
    .clk(clk), .rst_n(rst_n), .en(ram_en), .we(ram_we), .idx(ram_idx),
    .wdata(ram_wdata), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_buf_q    <= 1'b0;
      rd_buf_ok_q <= 1'b0;
    end else begin
      rd_buf_q    <= reg_rd && buf_hit;
      rd_buf_ok_q <= reg_rd && buf_hit && !cmd_start;
    end
  end

  assign reg_rdata = rd_buf_q ? (rd_buf_ok_q ? {56'd0, ram_q} : 64'd0) : regs_rdata;

  // R5
  mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cmd_start);

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != 32'd0) |=> (irq_set == 32'd0) && !cmd_start);
endmodule

// File: tb/byte_dma_engine_tb_top.sv
module byte_dma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_wide = 1'b0;
  logic [19:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = 8'h00;
  logic [31:0] irq_set;

  int checks = 0, fails = 0;
  longint cyc = 0;
  logic [7:0] sbuf [4096];

  // monitor state
  int     mon_n, mon_err, irq_n;
  longint mon_first, mon_last;
  logic [63:0] mon_host;
  logic [31:0] irq_val;
  logic   mon_dir;
  int     mon_sidx;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  byte_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wide(reg_wide), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq_set(irq_set)
  );

  function automatic logic [7:0] hb(input logic [63:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // host memory model: read data one clock after the request
  initial forever begin
    @(negedge clk);
    if (mem_req && !mem_we) begin
      logic [63:0] a;
      a = mem_addr;
      @(posedge clk);
      #1 mem_rdata = hb(a);
    end
  end

  // host port and interrupt monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && mem_req) begin
      if (mon_n == 0) mon_first = cyc;
      mon_last = cyc;
      if (mem_addr != mon_host + 64'(mon_n) || mem_we != mon_dir) mon_err++;
      if (mem_we && mem_wdata != sbuf[(mon_sidx + mon_n) % 4096]) mon_err++;
      mon_n++;
    end
    if (rst_n && irq_set != 32'd0) begin
      irq_n++;
      irq_val = irq_set;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  task automatic wr(input logic [19:0] a, input logic [63:0] d, input logic wide);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = wide;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // program, run and check one transfer
  task automatic xfer(input logic [63:0] src, input logic [63:0] dst, input logic [63:0] n,
                      input logic dir, input logic ien, input logic ok, input string tag);
    logic [63:0] v;
    longint t0;
    int bad, lidx, span;
    wr(20'h80, src, 1'b1);
    wr(20'h88, dst, 1'b1);
    wr(20'h90, n, 1'b1);
    mon_n = 0; mon_err = 0; irq_n = 0; irq_val = 0;
    mon_dir = dir; mon_host = dir ? dst : src;
    mon_sidx = int'(src[11:0]);
    t0 = cyc;
    wr(20'h98, {61'd0, ien, dir, 1'b1}, 1'b0);
    v = 64'd1;
    for (int k = 0; k < 400 && v[0]; k++) rd(20'h98, v);
    // R3: start clears within a bounded time after the count is done
    check(!v[0] && (cyc - t0) <= longint'(n) + 12, {tag, " R3 start clears"}, cyc - t0, n + 12);
    check(mon_n == (ok ? int'(n) : 0), {tag, " R4/R5 host access count (R8 R9 R12)"}, mon_n, ok ? n : 0);
    if (ok && n != 0)
      check(mon_last - mon_first + 1 == longint'(n), {tag, " R4 one byte per clock"},
            mon_last - mon_first + 1, n);
    check(mon_err == 0, {tag, " R4 R5 address/data order"}, mon_err, 0);
    check(irq_n == ((ok && ien) ? 1 : 0) && (irq_n == 0 || irq_val == 32'h100),
          {tag, " R7 interrupt"}, {32'(irq_n), irq_val}, (ok && ien) ? 64'h1_0000_0100 : 0);
    rd(20'h80, v); check(v == (ok ? src + n : src), {tag, " R6 source after"}, v, ok ? src + n : src);
    rd(20'h88, v); check(v == (ok ? dst + n : dst), {tag, " R6 dest after"}, v, ok ? dst + n : dst);
    rd(20'h90, v); check(v == (ok ? 0 : n), {tag, " R6 count after"}, v, ok ? 0 : n);
    if (ok && !dir)
      for (int k = 0; k < int'(n); k++) sbuf[(int'(dst[11:0]) + k) % 4096] = hb(src + 64'(k));
    // compare the buffer around the local end
    lidx = dir ? int'(src[11:0]) : int'(dst[11:0]);
    span = (n > 64'd64) ? 64 : int'(n) + 1;
    bad = 0;
    for (int k = 0; k < span; k++) begin
      int i;
      i = (lidx + k) % 4096;
      rd(20'h40000 + 20'(i), v);
      if (v != 64'(sbuf[i])) bad++;
    end
    check(bad == 0, {tag, " R4 R8 buffer contents"}, bad, 0);
  endtask

  initial begin
    logic [63:0] v;
    void'($urandom(32'd4711));
    for (int i = 0; i < 4096; i++) sbuf[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(!mem_req && irq_set == 0, "R1 outputs idle", {mem_req, irq_set}, 0);
    rd(20'h80, v); check(v == 0, "R1 source reset", v, 0);
    rd(20'h88, v); check(v == 0, "R1 dest reset", v, 0);
    rd(20'h90, v); check(v == 0, "R1 count reset", v, 0);
    rd(20'h98, v); check(v == 0, "R1 command reset", v, 0);
    // R2 access widths
    wr(20'h80, 64'h1122_3344_5566_7788, 1'b1);
    rd(20'h80, v); check(v == 64'h1122_3344_5566_7788, "R2 wide write", v, 64'h1122_3344_5566_7788);
    wr(20'h80, 64'hFFFF_FFFF_DEAD_BEEF, 1'b0);
    rd(20'h80, v); check(v == 64'h1122_3344_DEAD_BEEF, "R2 low half", v, 64'h1122_3344_DEAD_BEEF);
    wr(20'h84, 64'h0000_0000_CAFE_F00D, 1'b0);
    rd(20'h84, v); check(v == 64'hCAFE_F00D, "R2 high half read", v, 64'hCAFE_F00D);
    rd(20'h80, v); check(v == 64'hCAFE_F00D_DEAD_BEEF, "R2 merged", v, 64'hCAFE_F00D_DEAD_BEEF);
    wr(20'h98, 64'h6, 1'b0);
    rd(20'h98, v); check(v == 64'h6, "R3 command bits", v, 64'h6);
    // R11 buffer window; preload the whole buffer
    for (int i = 0; i < 4096; i++) wr(20'h40000 + 20'(i), {56'hFFFF_FFFF_FFFF_FF, sbuf[i]}, 1'b0);
    rd(20'h40010, v); check(v == 64'(sbuf[16]), "R11 buffer byte read", v, sbuf[16]);
    // directed transfers
    xfer(64'h1000, 64'h40000, 64'd100, 1'b0, 1'b1, 1'b1, "to-buffer");
    xfer(64'h40000, 64'h1064, 64'd100, 1'b1, 1'b0, 1'b1, "to-host");
    // edge of the window and of the mask
    xfer(64'h2000, 64'h40FFF, 64'd1, 1'b0, 1'b1, 1'b1, "last-byte");
    xfer(64'h2000, 64'h40FFF, 64'd2, 1'b0, 1'b1, 1'b0, "R8 past-window");
    xfer(64'h3FFFF, 64'h3000, 64'd4, 1'b1, 1'b1, 1'b0, "R8 below-window");
    xfer(64'h0FFF_FFFF, 64'h40100, 64'd1, 1'b0, 1'b0, 1'b1, "R9 mask-edge");
    xfer(64'h0FFF_FFFF, 64'h40100, 64'd2, 1'b0, 1'b1, 1'b0, "R9 over-mask");
    xfer(64'h40200, 64'h1000_0000, 64'd3, 1'b1, 1'b1, 1'b0, "R9 dest-over-mask");
    xfer(64'h5000, 64'h40300, 64'd0, 1'b0, 1'b1, 1'b1, "R12 zero-count");
    // R10 and R11: writes while busy
    wr(20'h80, 64'h8000, 1'b1);
    wr(20'h88, 64'h40400, 1'b1);
    wr(20'h90, 64'd40, 1'b1);
    mon_n = 0; mon_err = 0; irq_n = 0; mon_dir = 1'b0; mon_host = 64'h8000;
    wr(20'h98, 64'h1, 1'b0);
    wr(20'h80, 64'h9999, 1'b1);
    wr(20'h90, 64'd5, 1'b1);
    wr(20'h98, 64'h6, 1'b0);
    wr(20'h40F00, 64'h3C, 1'b0);
    rd(20'h40F00, v); check(v == 0, "R11 buffer read while busy", v, 0);
    v = 64'd1;
    for (int k = 0; k < 400 && v[0]; k++) rd(20'h98, v);
    check(v == 64'h0, "R10 command write ignored", v, 0);
    check(mon_n == 40 && mon_err == 0, "R10 transfer unaffected", mon_n, 40);
    rd(20'h80, v); check(v == 64'h8028, "R10 source write ignored", v, 64'h8028);
    rd(20'h90, v); check(v == 0, "R10 count write ignored", v, 0);
    for (int k = 0; k < 40; k++) sbuf[16'h400 + k] = hb(64'h8000 + 64'(k));
    rd(20'h40F00, v); check(v == 64'(sbuf[12'hF00]), "R11 buffer write while busy ignored", v, sbuf[12'hF00]);
    rd(20'h40427, v); check(v == 64'(sbuf[12'h427]), "R4 busy transfer data", v, sbuf[12'h427]);
    // random transfers
    for (int t = 0; t < 20; t++) begin
      logic [63:0] n, host, loc;
      logic d, ie;
      n    = 64'(1 + $urandom % 48);
      loc  = 64'h40000 + 64'($urandom % (4096 - int'(n) + 1));
      host = 64'($urandom & 32'h000F_FFFF);
      d    = 1'($urandom);
      ie   = 1'($urandom);
      if (d) xfer(loc, host, n, 1'b1, ie, 1'b1, "rand R5");
      else   xfer(host, loc, n, 1'b0, ie, 1'b1, "rand R4");
    end
    report();
  end
endmodule